// File: doc/BRIEF.md
# Test Access Port State Controller

This block is the sixteen-state sequencer at the heart of a boundary-scan test port. It runs on the test clock, reads the mode-select input on each rising edge, and moves through an idle loop and two parallel scan branches. One branch serves instruction scans and the other serves data scans. Its outputs are decoded strobes for the register paths that sit beside it. Capture and shift enables are valid for the whole cycle so that those registers can act on the next rising edge. Update strobes, the output-path select and the serial-output enable are re-timed to the falling edge, so that they only change there.

An active-low test reset clears the controller at once, whatever the clock is doing. Its release is synchronised to the rising edge, so the controller leaves the reset state only after a fixed number of clean edges. Holding mode-select high for five rising edges brings the controller back to reset from any state, without using the reset pin. If the clock stops low, every register keeps its value.

Top module: `tap_sequencer`

## Requirements
- R1: The state changes only on a rising `tck` edge, chosen by `tms` at that edge. `state_o` codes are: 0 reset, 1 idle, 2 data-select, 3 data-capture, 4 data-shift, 5 data-exit1, 6 data-pause, 7 data-exit2, 8 data-update, 9 instr-select, 10 instr-capture, 11 instr-shift, 12 instr-exit1, 13 instr-pause, 14 instr-exit2, 15 instr-update. Moves for `tms`=0 / `tms`=1: 0→1/0, 1→1/2, 2→3/9, 9→10/0, capture→shift/exit1, shift→shift/exit1, exit1→pause/update, pause→pause/exit2, exit2→shift/update, update→1/2.
- R2: `trst_n` low forces `state_o` to 0 at once, without waiting for a clock edge, and clears every falling-edge output. After `trst_n` rises, the state stays 0 for the first two rising edges whatever `tms` is, and `tms` takes effect from the third edge on.
- R3: Five consecutive rising edges with `tms`=1 leave the controller in state 0, from any starting state. Four such edges are not always enough.
- R4: `reset_o` is high exactly in state 0. `ir_capture_o` and `ir_shift_o` are high exactly in states 10 and 11. `dr_capture_o` and `dr_shift_o` are high exactly in states 3 and 4. All of these follow the state within the same cycle.
- R5: From either exit1 or exit2 state, `tms`=1 leads to the update state of the same branch. From exit1, `tms`=0 leads to pause. From exit2, `tms`=0 leads back to shift.
- R6: A pause state holds for any number of edges with `tms`=0. While it holds, no capture, shift or update strobe is raised.
- R7: `ir_update_o` (or `dr_update_o`) rises on the falling edge that falls inside state 15 (or 8). It falls on the falling edge of the following state, and it is still low just after the rising edge that enters the update state.
- R8: `tdo_oe_o` changes only on falling edges. After a falling edge it is high exactly when the state at that edge is 4 or 11.
- R9: `ir_sel_o` changes only on falling edges. After a falling edge it is high exactly when the state at that edge is one of 10 to 15, which steers the serial output to the instruction path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous active-low test reset |
| tms | input | 1 | Mode select, sampled on rising `tck` |
| state_o | output | 4 | Current controller state code |
| reset_o | output | 1 | High in the reset state |
| ir_capture_o | output | 1 | Instruction capture enable |
| ir_shift_o | output | 1 | Instruction shift enable |
| dr_capture_o | output | 1 | Data capture enable |
| dr_shift_o | output | 1 | Data shift enable |
| ir_update_o | output | 1 | Instruction update strobe, falling-edge timed |
| dr_update_o | output | 1 | Data update strobe, falling-edge timed |
| ir_sel_o | output | 1 | Serial output steering: 1 selects instruction path |
| tdo_oe_o | output | 1 | Serial output enable, falling-edge timed |

## Verification
A vector walk covers every state and both `tms` values out of every state. In it, long shift runs and repeated pause holds are kept apart from short scans that go straight from capture to exit and on to update. This separates a wrong exit decision from a wrong hold. The five-ones return is started from a pause and from a shift state, where a correct design needs exactly five edges. Each step compares the falling-edge outputs just after the rising edge against the previous state, and again after the falling edge against the new state. A strobe on the wrong edge therefore shows up at once. Reset is pulled mid-scan and released with `tms` low, which shows both the immediate clear and the two-edge release delay.

// File: rtl/tap_pkg.sv
package tap_pkg;

  localparam int STATE_W = 4;

  typedef enum logic [STATE_W-1:0] {
    ST_RESET      = 4'd0,
    ST_IDLE       = 4'd1,
    ST_DR_SELECT  = 4'd2,
    ST_DR_CAPTURE = 4'd3,
    ST_DR_SHIFT   = 4'd4,
    ST_DR_EXIT1   = 4'd5,
    ST_DR_PAUSE   = 4'd6,
    ST_DR_EXIT2   = 4'd7,
    ST_DR_UPDATE  = 4'd8,
    ST_IR_SELECT  = 4'd9,
    ST_IR_CAPTURE = 4'd10,
    ST_IR_SHIFT   = 4'd11,
    ST_IR_EXIT1   = 4'd12,
    ST_IR_PAUSE   = 4'd13,
    ST_IR_EXIT2   = 4'd14,
    ST_IR_UPDATE  = 4'd15
  } tap_state_e;

  // Strobes valid for the whole cycle, used on the next rising edge
  typedef struct packed {
    logic reset;
    logic ir_cap;
    logic ir_shift;
    logic dr_cap;
    logic dr_shift;
  } rise_ctl_t;

  // Signals re-timed to the falling edge
  typedef struct packed {
    logic ir_upd;
    logic dr_upd;
    logic ir_sel;
    logic tdo_oe;
  } fall_ctl_t;

endpackage

// File: rtl/tap_rst_sync.sv
module tap_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);

  generate
    if (STAGES == 1) begin : g_one
      logic sync_q;
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) sync_q <= 1'b0;
        else         sync_q <= 1'b1;
      end
      assign rst_n_o = sync_q;
    end else begin : g_multi
      logic [STAGES-1:0] sync_q;
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) sync_q <= '0;
        else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
      end
      assign rst_n_o = sync_q[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/tap_state_fsm.sv
module tap_state_fsm
  import tap_pkg::*;
(
  input  logic       tck,
  input  logic       rst_n,
  input  logic       tms,
  output tap_state_e state_q
);

  tap_state_e state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RESET:      state_d = tms ? ST_RESET      : ST_IDLE;
      ST_IDLE:       state_d = tms ? ST_DR_SELECT  : ST_IDLE;
      ST_DR_SELECT:  state_d = tms ? ST_IR_SELECT  : ST_DR_CAPTURE;
      ST_DR_CAPTURE: state_d = tms ? ST_DR_EXIT1   : ST_DR_SHIFT;
      ST_DR_SHIFT:   state_d = tms ? ST_DR_EXIT1   : ST_DR_SHIFT;
      ST_DR_EXIT1:   state_d = tms ? ST_DR_UPDATE  : ST_DR_PAUSE;
      ST_DR_PAUSE:   state_d = tms ? ST_DR_EXIT2   : ST_DR_PAUSE;
      ST_DR_EXIT2:   state_d = tms ? ST_DR_UPDATE  : ST_DR_SHIFT;
      ST_DR_UPDATE:  state_d = tms ? ST_DR_SELECT  : ST_IDLE;
      ST_IR_SELECT:  state_d = tms ? ST_RESET      : ST_IR_CAPTURE;
      ST_IR_CAPTURE: state_d = tms ? ST_IR_EXIT1   : ST_IR_SHIFT;
      ST_IR_SHIFT:   state_d = tms ? ST_IR_EXIT1   : ST_IR_SHIFT;
      ST_IR_EXIT1:   state_d = tms ? ST_IR_UPDATE  : ST_IR_PAUSE;
      ST_IR_PAUSE:   state_d = tms ? ST_IR_EXIT2   : ST_IR_PAUSE;
      ST_IR_EXIT2:   state_d = tms ? ST_IR_UPDATE  : ST_IR_SHIFT;
      ST_IR_UPDATE:  state_d = tms ? ST_DR_SELECT  : ST_IDLE;
      default:       state_d = ST_RESET;
    endcase
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) state_q <= ST_RESET;
    else        state_q <= state_d;
  end

endmodule

// File: rtl/tap_rise_decode.sv
module tap_rise_decode
  import tap_pkg::*;
(
  input  tap_state_e state,
  output rise_ctl_t  ctl
);

  always_comb begin
    ctl          = '0;
    ctl.reset    = (state == ST_RESET);
    ctl.ir_cap   = (state == ST_IR_CAPTURE);
    ctl.ir_shift = (state == ST_IR_SHIFT);
    ctl.dr_cap   = (state == ST_DR_CAPTURE);
    ctl.dr_shift = (state == ST_DR_SHIFT);
  end

endmodule

// File: rtl/tap_fall_stage.sv
module tap_fall_stage
  import tap_pkg::*;
(
  input  logic       tck,
  input  logic       rst_n,
  input  tap_state_e state,
  output fall_ctl_t  ctl_q
);

  fall_ctl_t ctl_d;

  always_comb begin
    ctl_d        = '0;
    ctl_d.ir_upd = (state == ST_IR_UPDATE);
    ctl_d.dr_upd = (state == ST_DR_UPDATE);
    ctl_d.ir_sel = (state >= ST_IR_CAPTURE);
    ctl_d.tdo_oe = (state == ST_IR_SHIFT) || (state == ST_DR_SHIFT);
  end

  always_ff @(negedge tck or negedge rst_n) begin
    if (!rst_n) ctl_q <= '0;
    else        ctl_q <= ctl_d;
  end

endmodule

// File: rtl/tap_sequencer.sv
module tap_sequencer
  import tap_pkg::*;
#(
  parameter int RST_SYNC_STAGES = 2
) (
  input  logic               tck,
  input  logic               trst_n,
  input  logic               tms,
  output logic [STATE_W-1:0] state_o,
  output logic               reset_o,
  output logic               ir_capture_o,
  output logic               ir_shift_o,
  output logic               dr_capture_o,
  output logic               dr_shift_o,
  output logic               ir_update_o,
  output logic               dr_update_o,
  output logic               ir_sel_o,
  output logic               tdo_oe_o
);

  logic       rst_n_sync;
  tap_state_e state_q;
  rise_ctl_t  rise_ctl;
  fall_ctl_t  fall_ctl;

  tap_rst_sync #(.STAGES(RST_SYNC_STAGES)) u_rst_sync (
    .clk     (tck),
    .arst_n  (trst_n),
    .rst_n_o (rst_n_sync)
  );

  tap_state_fsm u_fsm (
    .tck     (tck),
    .rst_n   (rst_n_sync),
    .tms     (tms),
    .state_q (state_q)
  );

  tap_rise_decode u_rise (
    .state (state_q),
    .ctl   (rise_ctl)
  );

  tap_fall_stage u_fall (
    .tck   (tck),
    .rst_n (rst_n_sync),
    .state (state_q),
    .ctl_q (fall_ctl)
  );

  assign state_o      = state_q;
  assign reset_o      = rise_ctl.reset;
  assign ir_capture_o = rise_ctl.ir_cap;
  assign ir_shift_o   = rise_ctl.ir_shift;
  assign dr_capture_o = rise_ctl.dr_cap;
  assign dr_shift_o   = rise_ctl.dr_shift;
  assign ir_update_o  = fall_ctl.ir_upd;
  assign dr_update_o  = fall_ctl.dr_upd;
  assign ir_sel_o     = fall_ctl.ir_sel;
  assign tdo_oe_o     = fall_ctl.tdo_oe;

endmodule

// File: rtl/tap_sequencer_chk.sv
module tap_sequencer_chk (
  input logic       tck,
  input logic       trst_n,
  input logic       rst_n,
  input logic       tms,
  input logic [3:0] state,
  input logic       ir_shift,
  input logic       ir_update,
  input logic       dr_update,
  input logic       tdo_oe
);

  logic [2:0] ones_q;

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n)              ones_q <= '0;
    else if (!tms)           ones_q <= '0;
    else if (ones_q != 3'd5) ones_q <= ones_q + 3'd1;
  end

  AST_ASYNC_CLEAR: assert property (@(posedge tck)
    !trst_n |-> (state == 4'd0 && !ir_update && !dr_update && !tdo_oe)); // R2

  AST_FIVE_ONES_RESET: assert property (@(posedge tck) disable iff (!rst_n)
    (ones_q == 3'd5) |-> (state == 4'd0)); // R3

  AST_SHIFT_ENTRY: assert property (@(posedge tck) disable iff (!rst_n)
    ir_shift |-> ($past(state) == 4'd10 || $past(state) == 4'd11 || $past(state) == 4'd14)); // R1

  AST_DR_EXIT_UPDATE: assert property (@(posedge tck) disable iff (!rst_n)
    ((state == 4'd5 || state == 4'd7) && tms) |=> (state == 4'd8)); // R5

  AST_IR_EXIT_UPDATE: assert property (@(posedge tck) disable iff (!rst_n)
    ((state == 4'd12 || state == 4'd14) && tms) |=> (state == 4'd15)); // R5

  AST_PAUSE_HOLD: assert property (@(posedge tck) disable iff (!rst_n)
    ((state == 4'd6 || state == 4'd13) && !tms) |=> $stable(state)); // R6

  AST_DR_UPDATE_IN_STATE: assert property (@(posedge tck) disable iff (!rst_n)
    dr_update |-> (state == 4'd8)); // R7

  AST_IR_UPDATE_IN_STATE: assert property (@(posedge tck) disable iff (!rst_n)
    ir_update |-> (state == 4'd15)); // R7

  AST_OE_IN_SHIFT: assert property (@(posedge tck) disable iff (!rst_n)
    tdo_oe |-> (state == 4'd4 || state == 4'd11)); // R8

endmodule

bind tap_sequencer tap_sequencer_chk u_chk (
  .tck       (tck),
  .trst_n    (trst_n),
  .rst_n     (rst_n_sync),
  .tms       (tms),
  .state     (state_o),
  .ir_shift  (ir_shift_o),
  .ir_update (ir_update_o),
  .dr_update (dr_update_o),
  .tdo_oe    (tdo_oe_o)
);

// File: tb/sim_tap_sequencer.sv
module sim_tap_sequencer;

  logic       tck = 1'b0;
  logic       trst_n;
  logic       tms;
  logic [3:0] state_o;
  logic       reset_o, ir_capture_o, ir_shift_o, dr_capture_o, dr_shift_o;
  logic       ir_update_o, dr_update_o, ir_sel_o, tdo_oe_o;

  int n_checks = 0;
  int n_fails  = 0;
  logic [3:0] prev_st;

  always #5 tck = ~tck;

  tap_sequencer u0 (
    .tck(tck), .trst_n(trst_n), .tms(tms), .state_o(state_o),
    .reset_o(reset_o), .ir_capture_o(ir_capture_o), .ir_shift_o(ir_shift_o),
    .dr_capture_o(dr_capture_o), .dr_shift_o(dr_shift_o),
    .ir_update_o(ir_update_o), .dr_update_o(dr_update_o),
    .ir_sel_o(ir_sel_o), .tdo_oe_o(tdo_oe_o)
  );

  // {tms, expected state after the edge}, starting from idle
  localparam int NVEC = 53;
  localparam logic [4:0] VEC [NVEC] = '{
    {1'b0,4'd1},  {1'b1,4'd2},  {1'b0,4'd3},  {1'b0,4'd4},  {1'b0,4'd4},
    {1'b1,4'd5},  {1'b0,4'd6},  {1'b0,4'd6},  {1'b1,4'd7},  {1'b0,4'd4},
    {1'b1,4'd5},  {1'b1,4'd8},  {1'b1,4'd2},  {1'b1,4'd9},  {1'b0,4'd10},
    {1'b1,4'd12}, {1'b0,4'd13}, {1'b1,4'd14}, {1'b1,4'd15}, {1'b0,4'd1},
    {1'b1,4'd2},  {1'b1,4'd9},  {1'b0,4'd10}, {1'b0,4'd11}, {1'b1,4'd12},
    {1'b1,4'd15}, {1'b1,4'd2},  {1'b0,4'd3},  {1'b1,4'd5},  {1'b1,4'd8},
    {1'b0,4'd1},  {1'b1,4'd2},  {1'b0,4'd3},  {1'b1,4'd5},  {1'b0,4'd6},
    {1'b1,4'd7},  {1'b1,4'd8},  {1'b1,4'd2},  {1'b1,4'd9},  {1'b0,4'd10},
    {1'b0,4'd11}, {1'b0,4'd11}, {1'b1,4'd12}, {1'b0,4'd13}, {1'b0,4'd13},
    {1'b1,4'd14}, {1'b0,4'd11}, {1'b1,4'd12}, {1'b1,4'd15}, {1'b1,4'd2},
    {1'b1,4'd9},  {1'b1,4'd0},  {1'b1,4'd0}
  };

  // R4: {reset, ir_capture, ir_shift, dr_capture, dr_shift}
  function automatic logic [4:0] exp_rise(input logic [3:0] st);
    return {st == 4'd0, st == 4'd10, st == 4'd11, st == 4'd3, st == 4'd4};
  endfunction

  // R7 R8 R9: {ir_update, dr_update, ir_sel, tdo_oe}
  function automatic logic [3:0] exp_fall(input logic [3:0] st);
    return {st == 4'd15, st == 4'd8, st >= 4'd10, (st == 4'd4) || (st == 4'd11)};
  endfunction

  task automatic check(input string tag, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [4:0] rise_now();
    return {reset_o, ir_capture_o, ir_shift_o, dr_capture_o, dr_shift_o};
  endfunction

  function automatic logic [3:0] fall_now();
    return {ir_update_o, dr_update_o, ir_sel_o, tdo_oe_o};
  endfunction

  // Called at falling edge + 1; returns at falling edge + 1
  task automatic step(input logic t, input logic [3:0] exp, input string tag);
    tms = t;
    @(posedge tck); #1;
    check(tag, "state", {4'd0, state_o}, {4'd0, exp});
    check("R4", "rise strobes", {3'd0, rise_now()}, {3'd0, exp_rise(exp)});
    check("R7 R8 R9", "fall outputs before falling edge",
          {4'd0, fall_now()}, {4'd0, exp_fall(prev_st)});
    @(negedge tck); #1;
    check("R7 R8 R9", "fall outputs after falling edge",
          {4'd0, fall_now()}, {4'd0, exp_fall(exp)});
    prev_st = exp;
  endtask

  initial begin
    #200000;
    n_fails++;
    n_checks++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
    $finish;
  end

  initial begin
    trst_n  = 1'b0;
    tms     = 1'b1;
    prev_st = 4'd0;
    #23;
    // R2: reset state while trst_n is held low
    check("R2", "state in reset", {4'd0, state_o}, 8'd0);
    check("R2", "rise in reset", {3'd0, rise_now()}, 8'h10);
    check("R2", "fall in reset", {4'd0, fall_now()}, 8'h00);

    // R2: release with tms low: two edges held, third moves
    @(negedge tck); #1;
    trst_n = 1'b1;
    step(1'b0, 4'd0, "R2");
    step(1'b0, 4'd0, "R2");
    step(1'b0, 4'd1, "R2");

    // R1 R5: vector walk through every state
    for (int i = 0; i < NVEC; i++) begin
      step(VEC[i][4], VEC[i][3:0], "R1 R5");
    end

    // R3 from data pause: exactly five ones needed
    step(1'b0, 4'd1, "R1");
    step(1'b1, 4'd2, "R1");
    step(1'b0, 4'd3, "R1");
    step(1'b0, 4'd4, "R1");
    step(1'b1, 4'd5, "R1");
    step(1'b0, 4'd6, "R1");
    step(1'b1, 4'd7, "R3");
    step(1'b1, 4'd8, "R3");
    step(1'b1, 4'd2, "R3");
    step(1'b1, 4'd9, "R3");
    step(1'b1, 4'd0, "R3");

    // R3 from instruction shift
    step(1'b0, 4'd1, "R1");
    step(1'b1, 4'd2, "R1");
    step(1'b1, 4'd9, "R1");
    step(1'b0, 4'd10, "R1");
    step(1'b0, 4'd11, "R1");
    step(1'b1, 4'd12, "R3");
    step(1'b1, 4'd15, "R3");
    step(1'b1, 4'd2, "R3");
    step(1'b1, 4'd9, "R3");
    step(1'b1, 4'd0, "R3");

    // R6: long hold in instruction pause
    step(1'b0, 4'd1, "R1");
    step(1'b1, 4'd2, "R1");
    step(1'b1, 4'd9, "R1");
    step(1'b0, 4'd10, "R1");
    step(1'b1, 4'd12, "R5");
    step(1'b0, 4'd13, "R5");
    for (int k = 0; k < 6; k++) begin
      step(1'b0, 4'd13, "R6");
    end
    step(1'b1, 4'd14, "R6");
    step(1'b1, 4'd15, "R5");
    step(1'b0, 4'd1, "R1");

    // R2: asynchronous reset in the middle of a data shift
    step(1'b1, 4'd2, "R1");
    step(1'b0, 4'd3, "R1");
    step(1'b0, 4'd4, "R1");
    check("R8", "oe in shift", {7'd0, tdo_oe_o}, 8'd1);
    trst_n = 1'b0;
    #1;
    check("R2", "state on async reset", {4'd0, state_o}, 8'd0);
    check("R2", "fall on async reset", {4'd0, fall_now()}, 8'h00);
    check("R2", "rise on async reset", {3'd0, rise_now()}, 8'h10);
    @(negedge tck); #1;
    trst_n  = 1'b1;
    prev_st = 4'd0;
    step(1'b0, 4'd0, "R2");
    step(1'b0, 4'd0, "R2");
    step(1'b0, 4'd1, "R2");

    $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
    $finish;
  end

endmodule